// File: doc/BRIEF.md
# Watchdog Timer with Byte Register Window

This block is a watchdog timer that a host controls through an eight-byte register window. The host writes a 24-bit reload value as three separate seed bytes, then arms the timer with two control writes. The first clears any earlier state and the second, the "pet", loads the seed into a down-counter and starts it. The counter loses one count per tick. A tick is a fixed number of clock cycles set by a parameter. If the host does not pet the timer again before the count runs out, the block raises an alarm.

On expiry the block stops counting and sets a sticky alarm flag. It drives a one-cycle interrupt pulse. If the processor-reset enable is set, it also drives a reset output for a set number of clocks. The live count is never read directly. A capture strobe copies all 24 bits at once into three readable bytes, so a read that spans several bus cycles always sees a single, consistent value.

Top module: `wdog_bytewin`

## Requirements
- R1: After reset, all eight byte offsets read 0x00 and both `alarm_irq` and `cpu_rst_o` are low.
- R2: Offsets 7, 6 and 5 hold the seed's low, middle and high bytes. They can be written at any time and read back unchanged.
- R3: The control byte is at offset 1. Its strobe bits are pet (bit 4), capture (bit 2) and clear (bit 1), and they read as 0. A pet loads the seed into the counter and sets the running flag (bit 3). After the pet, the counter drops by one every TICK_DIV clocks.
- R4: Suppose the seed S is loaded by a pet on edge p. On edge p + S·TICK_DIV the counter reaches 0, running clears, the sticky alarm flag (bit 0) sets, and `alarm_irq` is high for exactly one cycle. The counter then holds at 0.
- R5: A pet given before expiry reloads the seed and restarts the tick phase, so no alarm occurs.
- R6: Writing the capture bit copies the count into offsets 2 (high), 3 (middle) and 4 (low). The copy holds the value from before that edge. It stays frozen while the live counter keeps moving.
- R7: A seed write made while the timer is running does not change the live count. The new value is used only at the next pet.
- R8: A clear strobe stops the counter, drops running and clears the alarm flag. The count then holds its value.
- R9: If processor-reset enable (bit 5) is set at expiry, `cpu_rst_o` goes high on the expiry edge and stays high for RST_LEN clocks. If the bit is clear, `cpu_rst_o` stays low.
- R10: The mode bit (bit 7) and processor-reset enable are stored and read back. Writes to the running and alarm bit positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte this cycle |
| addr | input | 3 | Byte offset within the window |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| alarm_irq | output | 1 | One-cycle pulse on expiry |
| cpu_rst_o | output | 1 | Processor reset pulse, RST_LEN clocks long |

## Verification
A prescaler with the wrong phase after a pet moves the expiry edge by up to TICK_DIV cycles. It also shifts every captured value. So the bench compares each capture, and the exact alarm edge, against the count computed from the number of edges since the pet. A bad counter or seed latch shows up at the very next capture as a wrong 24-bit value. A snapshot that is not frozen shows up when the three bytes are read many cycles apart. A stale running or alarm flag shows at once in the control byte, and by the end of the test in a missing or extra `alarm_irq` pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_BYTES = 3;
  localparam int CNT_W     = 8 * CNT_BYTES;

  localparam logic [2:0] OFS_CTRL    = 3'd1;
  localparam logic [2:0] OFS_CNT_LO  = 3'd4;
  localparam logic [2:0] OFS_SEED_LO = 3'd7;

  localparam int BIT_MODE  = 7;
  localparam int BIT_PRST  = 5;
  localparam int BIT_PET   = 4;
  localparam int BIT_RUN   = 3;
  localparam int BIT_CAP   = 2;
  localparam int BIT_CLR   = 1;
  localparam int BIT_ALARM = 0;

  // saturating decrement of the live count
  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // control byte as seen by a read; strobe positions read as zero
  function automatic logic [7:0] ctrl_pack(input logic mode, input logic prst,
                                           input logic run, input logic alarm);
    logic [7:0] b;
    b = '0;
    b[BIT_MODE]  = mode;
    b[BIT_PRST]  = prst;
    b[BIT_RUN]   = run;
    b[BIT_ALARM] = alarm;
    return b;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_DIV = 3072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (restart || !run)  pre_q <= '0;
    else if (pre_q == LAST)    pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= seed;
    else if (run && tick) cnt_q <= wdog_pkg::dec_sat(cnt_q);
  end

  assign cnt    = cnt_q;
  assign expire = run && tick && !load && (cnt_q <= W'(1));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int RW = $clog2(LEN + 1);
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rem_q <= '0;
    else if (trig)        rem_q <= RW'(LEN);
    else if (rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign pulse = (rem_q != '0);
endmodule

// File: rtl/wdog_bytewin.sv
module wdog_bytewin
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 3072,
  parameter int RST_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       alarm_irq,
  output logic       cpu_rst_o
);
  // decoded write events
  logic ctrl_wr, pet_stb, cap_stb, clr_stb;
  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign pet_stb = ctrl_wr && wr_data[BIT_PET];
  assign cap_stb = ctrl_wr && wr_data[BIT_CAP];
  assign clr_stb = ctrl_wr && wr_data[BIT_CLR];

  // seed bytes, one register per byte lane
  logic [7:0]       seed_b [CNT_BYTES];
  logic [CNT_W-1:0] seed_q;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_seed
    localparam logic [2:0] OFS = 3'(int'(OFS_SEED_LO) - b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        seed_b[b] <= '0;
      else if (wr_en && (addr == OFS))   seed_b[b] <= wr_data;
    end
    assign seed_q[8*b +: 8] = seed_b[b];
  end

  // control state
  logic mode_q, prst_q, run_q, alarm_q, irq_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] cnt_q;
  logic tick, expire, fire;

  assign fire = expire && !clr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      prst_q  <= 1'b0;
      run_q   <= 1'b0;
      alarm_q <= 1'b0;
      irq_q   <= 1'b0;
      snap_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= wr_data[BIT_MODE];
        prst_q <= wr_data[BIT_PRST];
      end
      if (pet_stb)                 run_q <= 1'b1;
      else if (clr_stb || expire)  run_q <= 1'b0;
      if (clr_stb)                 alarm_q <= 1'b0;
      else if (expire)             alarm_q <= 1'b1;
      irq_q <= fire;
      if (cap_stb) snap_q <= cnt_q;
    end
  end

  wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(pet_stb), .tick(tick)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(pet_stb), .seed(seed_q),
    .run(run_q), .tick(tick), .cnt(cnt_q), .expire(expire)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(fire && prst_q), .pulse(cpu_rst_o)
  );

  assign alarm_irq = irq_q;

  // read mux
  always_comb begin
    rd_data = '0;
    if (addr == OFS_CTRL) rd_data = ctrl_pack(mode_q, prst_q, run_q, alarm_q);
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (addr == 3'(int'(OFS_CNT_LO) - b))  rd_data = snap_q[8*b +: 8];
      if (addr == 3'(int'(OFS_SEED_LO) - b)) rd_data = seed_b[b];
    end
  end
endmodule

// File: rtl/wdog_bytewin_chk.sv
module wdog_bytewin_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         running,
  input logic         alarm_flag,
  input logic         irq,
  input logic         cpu_rst,
  input logic         pet,
  input logic         tick,
  input logic [W-1:0] cnt
);
  // R4: interrupt is a single-cycle pulse
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R4: interrupt comes with the sticky flag and a stopped counter
  p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alarm_flag && !running));
  // R3: one count lost per tick while running
  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !pet && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R8: a stopped counter holds its value until a pet
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !pet) |=> $stable(cnt));
  // R9: processor reset starts only together with the alarm
  p_rst_with_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> irq);
endmodule

bind wdog_bytewin wdog_bytewin_chk #(.W(wdog_pkg::CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .running(run_q), .alarm_flag(alarm_q),
  .irq(alarm_irq), .cpu_rst(cpu_rst_o), .pet(pet_stb), .tick(tick), .cnt(cnt_q)
);

// File: tb/wdog_bytewin_tb_top.sv
module wdog_bytewin_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int RL = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_irq, cpu_rst_o;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int irq_seen = 0;
  int last_edge = 0;
  bit done = 0;

  wdog_bytewin #(.TICK_DIV(TD), .RST_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .alarm_irq(alarm_irq), .cpu_rst_o(cpu_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;
  always @(negedge clk) if (rst_n && alarm_irq) irq_seen++;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    last_edge = edges;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic set_seed(input int s);
    wr(3'd5, 8'((s >> 16) & 255));
    wr(3'd6, 8'((s >> 8) & 255));
    wr(3'd7, 8'(s & 255));
  endtask

  function automatic int cnt_after(input int s, input int p, input int e);
    int k;
    k = (e - p) / TD;
    return (k >= s) ? 0 : s - k;
  endfunction

  // capture, then read high/mid/low with gap cycles between bytes
  task automatic capture(input logic [7:0] keep, input int gap,
                         output int val, output int cedge);
    logic [7:0] h, m, l;
    wr(3'd1, keep | 8'h04);
    cedge = last_edge;
    rd(3'd2, h);
    repeat (gap) @(negedge clk);
    rd(3'd3, m);
    repeat (gap) @(negedge clk);
    rd(3'd4, l);
    val = {8'h00, h, m, l};
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int p, v, c, v2, r, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      rd(3'(a), d);
      chk("R1 byte", d, 0);
    end
    chk("R1 irq", alarm_irq, 0);
    chk("R1 cpu_rst", cpu_rst_o, 0);

    // R2: seed bytes at offsets 5/6/7 read back
    wr(3'd5, 8'hA5); wr(3'd6, 8'h5A); wr(3'd7, 8'hC3);
    rd(3'd5, d); chk("R2 seed hi", d, 8'hA5);
    @(negedge clk); rd(3'd6, d); chk("R2 seed mid", d, 8'h5A);
    @(negedge clk); rd(3'd7, d); chk("R2 seed lo", d, 8'hC3);

    // R10: mode and prst stored; running/alarm positions ignored
    wr(3'd1, 8'hE9);
    rd(3'd1, d); chk("R10 ctrl readback", d, 8'hA0);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R10 ctrl cleared", d, 8'h00);

    // R3: clear then pet arms the counter
    set_seed(40);
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h10);
    p = last_edge;
    rd(3'd1, d); chk("R3 running after pet", d, 8'h08);

    // R6: capture sweep while counting, bytes read several cycles apart
    for (int i = 0; i < 6; i++) begin
      repeat (i + 1) @(negedge clk);
      capture(8'h00, 3, v, c);
      chk("R6 R3 capture value", v, cnt_after(40, p, c - 1));
    end
    repeat (7) @(negedge clk);
    rd(3'd2, d); v2 = {8'h00, d, 16'h0};
    rd(3'd3, d); v2 |= {16'h0, d, 8'h0};
    rd(3'd4, d); v2 |= {24'h0, d};
    chk("R6 snapshot frozen", v2, v);

    // R7: seed write while running leaves live count alone
    set_seed(12);
    capture(8'h00, 0, v, c);
    chk("R7 live count unchanged", v, cnt_after(40, p, c - 1));

    // R5: pets before expiry reload and prevent the alarm
    for (int i = 0; i < 4; i++) begin
      wr(3'd1, 8'h10);
      p = last_edge;
      repeat (30) @(negedge clk);
      capture(8'h00, 0, v, c);
      chk("R5 reload value", v, cnt_after(12, p, c - 1));
    end
    chk("R5 no alarm", irq_seen, 0);
    rd(3'd1, d); chk("R5 still running", d, 8'h08);

    // R4: expiry timing, prst disabled
    set_seed(3);
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h10);
    p = last_edge;
    repeat (3 * TD - 1) @(negedge clk);
    chk("R4 no irq before expiry", alarm_irq, 0);
    rd(3'd1, d); chk("R4 running before expiry", d, 8'h08);
    @(negedge clk);
    chk("R4 irq at expiry", alarm_irq, 1);
    rd(3'd1, d); chk("R4 alarm set, running clear", d, 8'h01);
    chk("R9 no cpu reset when disabled", cpu_rst_o, 0);
    @(negedge clk);
    chk("R4 irq one cycle", alarm_irq, 0);
    repeat (20) @(negedge clk);
    capture(8'h00, 0, v, c);
    chk("R4 count held at zero", v, 0);
    chk("R4 single irq", irq_seen, 1);
    chk("R9 cpu reset stays low", cpu_rst_o, 0);

    // R8: clear drops alarm; clear while running freezes the count
    wr(3'd1, 8'h02);
    rd(3'd1, d); chk("R8 alarm cleared", d, 8'h00);
    set_seed(10);
    wr(3'd1, 8'h10);
    p = last_edge;
    repeat (9) @(negedge clk);
    wr(3'd1, 8'h02);
    r = last_edge;
    capture(8'h00, 0, v, c);
    chk("R8 stopped value", v, cnt_after(10, p, r));
    repeat (60) @(negedge clk);
    capture(8'h00, 0, v2, c);
    chk("R8 count frozen", v2, v);
    rd(3'd1, d); chk("R8 not running", d, 8'h00);
    chk("R8 no alarm after clear", irq_seen, 1);

    // R9: processor reset pulse length
    set_seed(2);
    wr(3'd1, 8'h22);
    wr(3'd1, 8'h30);
    p = last_edge;
    repeat (2 * TD - 1) @(negedge clk);
    chk("R9 low before expiry", cpu_rst_o, 0);
    @(negedge clk);
    chk("R9 high at expiry", cpu_rst_o, 1);
    chk("R9 irq with reset", alarm_irq, 1);
    rd(3'd1, d); chk("R9 R10 ctrl prst+alarm", d, 8'h21);
    n = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_rst_o) n++;
    end
    chk("R9 pulse length", n, RL);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule